// File: doc/BRIEF.md
# Comparator Event Flag Controller

This block is the digital side of an analog voltage comparator. It brings the comparator's raw decision bit into the clock domain through a synchronizer. It holds that bit in a filtered output register and watches it for the transitions that a two-bit mode field selects. A selected transition sets a sticky event flag, which software clears by writing a one. The flag can raise an interrupt request. The filtered bit can also replace a timer pin as the source of a capture channel.

Each time the comparator is switched on, the whole downstream path is frozen for a fixed settling window of bus clock cycles. That path is the output bit, the flag and the capture link. When the comparator is switched off, the path keeps its last value. Software reaches the block through a tiny two-register bus: one control register and one status register. A further control bit is passed straight out to enable the digital input buffers on both comparator pins.

Top module: `cmpflag_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0. `irq` and `dig_buf_en` are 0, and `capture_in` follows `timer_pin`.
- R2: Control bits [5:4] form the mode field. With 00 the flag never sets. With 01 it sets on a rising transition, with 10 on a falling transition, and with 11 on either.
- R3: Status bit 0 is the event flag. It stays set until a write to address 1 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged.
- R4: Status bit 1 is the filtered comparator output and is read-only. Writes to address 1 do not change it.
- R5: While the comparator is enabled (control bit 0) and not blanking, a change on `cmp_raw` reaches status bit 1 and the flag on the third rising clock edge after it, and not earlier.
- R6: A write that takes control bit 0 from 0 to 1 starts a window of BLANK_CYCLES (63) cycles. During the window the output bit, the flag and the capture link hold their values. The output first updates at the 64th edge after the write edge. The update at the end of the window does not set the flag.
- R7: While control bit 0 is 0, the output bit holds its last value and no flag is set, whatever `cmp_raw` does.
- R8: With control bit 1 equal to 1, `capture_in` carries the filtered output. With control bit 1 equal to 0, `capture_in` carries `timer_pin`.
- R9: `dig_buf_en` equals control bit 2.
- R10: `irq` is 1 exactly when the flag is set and control bit 3 (interrupt enable) is 1.
- R11: When a flag-setting event and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator decision, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| timer_pin | input | 1 | Timer capture pin |
| capture_in | output | 1 | Signal delivered to the capture channel |
| irq | output | 1 | Interrupt request |
| dig_buf_en | output | 1 | Digital input buffer enable for both comparator pins |

## Verification
All four mode codes are swept, and each is given a rising transition and a falling transition. This separates the modes that react to one direction, to the other direction, to both directions and to neither. The same sweep samples the output one edge before and at its expected update, which pins the synchronizer latency. A level difference is built up across the settling window, with extra toggles inside it. This shows the freeze itself, the exact cycle of release, and that the release raises no flag. Further patterns disable the comparator under a moving input, put a clear in the same cycle as an event, and flip the routing and interrupt bits.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTRL_W = 6;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_OUT_BIT  = 1;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RISE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e mode;      // [5:4]
    logic       irq_en;    // [3]
    logic       buf_en;    // [2]
    logic       cap_route; // [1]
    logic       enable;    // [0]
  } ctrl_t;

endpackage

// File: rtl/cmpflag_edge.sv
module cmpflag_edge
  import cmpflag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       live,
  input  edge_mode_e mode,
  output logic       cmp_s,
  output logic       set_evt
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   dly_q, dly_d;
  logic                   rise, fall;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = cmp_raw;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  assign cmp_s = sync_q[SYNC_STAGES-1];
  assign dly_d = cmp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      dly_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    rise    = cmp_s & ~dly_q;
    fall    = ~cmp_s & dly_q;
    set_evt = 1'b0;
    if (live) begin
      unique case (mode)
        MODE_RISE: set_evt = rise;
        MODE_FALL: set_evt = fall;
        MODE_BOTH: set_evt = rise | fall;
        default:   set_evt = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cmpflag_hold.sv
module cmpflag_hold #(
  parameter int unsigned BLANK_CYCLES = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic en_rise,
  input  logic cmp_s,
  output logic live,
  output logic path_q
);

  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             path_d;
  logic             blanking;

  assign blanking = (cnt_q != '0);
  assign live     = enable & ~blanking;

  always_comb begin
    cnt_d = cnt_q;
    if (en_rise) begin
      cnt_d = CNT_LOAD;
    end else if (blanking) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    path_d = path_q;
    if (live) begin
      path_d = cmp_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      path_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      path_q <= path_d;
    end
  end

  // R6
  window_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |=> $stable(path_q));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(path_q));

endmodule

// File: rtl/cmpflag_regs.sv
module cmpflag_regs
  import cmpflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_evt,
  input  logic              path_val,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              en_rise,
  output logic [DATA_W-1:0] rdata
);

  ctrl_t ctrl_q, ctrl_d;
  logic  flag_q, flag_d;
  logic  clr;

  always_comb begin
    ctrl_d  = ctrl_q;
    en_rise = 1'b0;
    clr     = wr && (addr == ADDR_STAT) && wdata[STAT_FLAG_BIT];
    if (wr && (addr == ADDR_CTRL)) begin
      ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
      en_rise = ctrl_d.enable & ~ctrl_q.enable;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (set_evt) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[CTRL_W-1:0] = ctrl_q;
    end else begin
      rdata[STAT_FLAG_BIT] = flag_q;
      rdata[STAT_OUT_BIT]  = path_val;
    end
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R3
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr && addr == ADDR_STAT)) |=> flag_q);

endmodule

// File: rtl/cmpflag_ctrl.sv
module cmpflag_ctrl
  import cmpflag_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 63,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timer_pin,
  output logic              capture_in,
  output logic              irq,
  output logic              dig_buf_en
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  ctrl_t      ctrl;
  logic       flag, en_rise, live, path_q, cmp_s, set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  cmpflag_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmp_raw (cmp_raw),
    .live    (live),
    .mode    (ctrl.mode),
    .cmp_s   (cmp_s),
    .set_evt (set_evt)
  );

  cmpflag_hold #(.BLANK_CYCLES(BLANK_CYCLES)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .enable  (ctrl.enable),
    .en_rise (en_rise),
    .cmp_s   (cmp_s),
    .live    (live),
    .path_q  (path_q)
  );

  cmpflag_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .set_evt  (set_evt),
    .path_val (path_q),
    .ctrl     (ctrl),
    .flag     (flag),
    .en_rise  (en_rise),
    .rdata    (bus_rdata)
  );

  assign capture_in = ctrl.cap_route ? path_q : timer_pin;
  assign irq        = flag & ctrl.irq_en;
  assign dig_buf_en = ctrl.buf_en;

  // R2
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl.mode == MODE_OFF && !bus_rdata[STAT_FLAG_BIT] && bus_addr == ADDR_STAT) |=> !flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (flag && ctrl.irq_en));

endmodule

// File: tb/cmpflag_ctrl_tb.sv
module cmpflag_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       timer_pin = 1'b0;
  logic       capture_in, irq, dig_buf_en;

  int checks = 0;
  int failures = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  cmpflag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_pin(timer_pin), .capture_in(capture_in), .irq(irq),
    .dig_buf_en(dig_buf_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, rv); check("R1 ctrl", rv, 8'h00);
    rd(1'b1, rv); check("R1 status", rv, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 buf", {7'b0, dig_buf_en}, 8'h00);
    timer_pin = 1'b1; #0.5;
    check("R1 capture", {7'b0, capture_in}, 8'h01);
    timer_pin = 1'b0;

    // R6 blanking window with a level difference and toggles inside it
    cmp_raw = 1'b1;
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h31);             // mode both, enable
    repeat (10) @(negedge clk);
    cmp_raw = 1'b0;
    repeat (10) @(negedge clk);
    cmp_raw = 1'b1;
    repeat (43) @(posedge clk);  // write edge + 63
    @(negedge clk);
    rd(1'b1, rv); check("R6 frozen at edge 63", rv, 8'h00);
    @(negedge clk);
    rd(1'b1, rv); check("R6 released at edge 64 no flag", rv, 8'h02);

    // R2 and R5: sweep of all modes over both directions
    for (int m = 0; m < 4; m++) begin
      wr(1'b0, 8'((m << 4) | 1));
      for (int d = 0; d < 2; d++) begin
        logic st;
        logic exp_flag;
        st = (d == 0) ? 1'b0 : 1'b1;
        cmp_raw = st;
        repeat (6) @(negedge clk);
        wr(1'b1, 8'h01);
        cmp_raw = ~st;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(1'b1, rv); check("R5 not before third edge", {6'b0, rv[1], 1'b0}, {6'b0, st, 1'b0});
        @(negedge clk);
        rd(1'b1, rv); check("R5 output at third edge", {6'b0, rv[1], 1'b0}, {6'b0, ~st, 1'b0});
        exp_flag = (d == 0) ? m[0] : m[1];
        check("R2 flag per mode", {7'b0, rv[0]}, {7'b0, exp_flag});
      end
    end

    // now mode both, out=1, flag set (falling? last was d=1: out 0, flag set)
    cmp_raw = 1'b1;
    repeat (5) @(negedge clk);
    // R3 write 0 keeps flag
    wr(1'b1, 8'h00);
    rd(1'b1, rv); check("R3 write zero keeps flag", rv, 8'h03);
    // R4 write to output bit ignored
    wr(1'b1, 8'h02);
    rd(1'b1, rv); check("R4 output not writable", rv, 8'h03);
    // R10 interrupt gating
    check("R10 irq off when disabled", {7'b0, irq}, 8'h00);
    wr(1'b0, 8'h39);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    // R3 clear
    wr(1'b1, 8'h01);
    rd(1'b1, rv); check("R3 write one clears", rv, 8'h02);
    check("R10 irq follows clear", {7'b0, irq}, 8'h00);

    // R11 set and clear in the same cycle
    cmp_raw = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(1'b1, rv); check("R11 set beats clear", rv, 8'h01);
    wr(1'b1, 8'h01);

    // R8 capture routing
    timer_pin = 1'b1; #0.5;
    check("R8 pin path", {7'b0, capture_in}, 8'h01);
    wr(1'b0, 8'h33);
    check("R8 comparator path", {7'b0, capture_in}, 8'h00);
    cmp_raw = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 comparator path follows", {7'b0, capture_in}, 8'h01);
    // R9 buffer enable
    wr(1'b0, 8'h37);
    check("R9 buffer on", {7'b0, dig_buf_en}, 8'h01);
    wr(1'b0, 8'h33);
    check("R9 buffer off", {7'b0, dig_buf_en}, 8'h00);

    // R7 disable holds last state
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h30);
    cmp_raw = 1'b0;
    repeat (10) @(negedge clk);
    cmp_raw = 1'b1;
    repeat (3) @(negedge clk);
    cmp_raw = 1'b0;
    repeat (10) @(negedge clk);
    rd(1'b1, rv); check("R7 held while off", rv, 8'h02);

    finish_run();
  end

endmodule